// File: doc/BRIEF.md
# Eight-Level Vectored Priority Interrupt Controller

This block collects interrupt requests from eight input lines and presents one interrupt output to a processor. Each input is synchronized, and a request is latched on its rising edge. Latched requests pass through a mask. They are then compared with the levels the processor is already servicing. The output is raised only for a request that is allowed to preempt the current work. Line 0 has the highest priority and line 7 the lowest, and priority is fully nested.

The processor answers the interrupt output with two acknowledge pulses. The first pulse moves the winning level from the pending set to the in-service set. The second pulse produces an 8-bit vector. The upper five bits of the vector come from a programmed base, and the lower three bits are the level number. The handler ends its work by issuing an end-of-interrupt command. This command retires the highest-priority level that is in service.

A small write port programs the vector base and the mask, and issues the end-of-interrupt command. The port uses one select field and one data byte.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Line 0 has the highest priority and line 7 the lowest. When several unmasked requests are eligible, the first acknowledge takes the one with the lowest line number.
- R2: The vector is formed as follows. Bits 7..3 are bits 7..3 of the last value written with `wr_sel` = 0 (base). Bits 2..0 are the acknowledged line number. Bits 2..0 of the written base have no effect.
- R3: A write with `wr_sel` = 1 loads the mask, where bit i = 1 masks line i. A masked request never raises `intr`. It stays latched, and it raises `intr` once its mask bit is cleared.
- R4: `intr` rises only for an unmasked pending request whose priority is strictly higher than every level in service. A request of equal or lower priority waits.
- R5: The first acknowledge pulse clears the winning request bit, sets the matching in-service bit, and drops `intr`.
- R6: `vec_out` carries the vector for exactly one cycle, the cycle after the second acknowledge pulse. At all other times it is zero.
- R7: Once `intr` is high, it stays high until the first acknowledge pulse, as long as the mask is not rewritten.
- R8: A write with `wr_sel` = 2 is an end-of-interrupt command. It clears only the highest-priority in-service bit, and `wr_data` is ignored.
- R9: A request of higher priority than the level in service is acknowledged on top of it, and both levels then stay in service.
- R10: Requests are taken on rising edges. `intr` rises at the fourth clock edge after a line goes high. A line that stays high after it has been acknowledged does not request again.
- R11: An acknowledge sequence that arrives with no eligible request returns the vector for line 7 and leaves the request and in-service state unchanged.
- R12: Reset clears the pending and in-service state and the base, sets every mask bit, and drives `intr` and `vec_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines; bit i is line i |
| wr_en | input | 1 | Write strobe for the command port |
| wr_sel | input | 2 | 0 base, 1 mask, 2 end-of-interrupt, 3 no operation |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Acknowledge pulse, one cycle per pulse |
| intr | output | 1 | Interrupt request to the processor (registered) |
| vec_out | output | 8 | Vector, valid for one cycle after the second acknowledge |

## Verification
Each result has a fixed latency, and the bench counts registers to find it. A line that rises before an edge is seen on `intr` at the fourth edge after that; the bench checks that `intr` is still low after three edges and high after four. A mask write or end-of-interrupt command first updates state at its own edge, and `intr` follows at the next edge. The bench therefore samples `intr` two falling edges after the write. The vector is sampled at the falling edge right after the second acknowledge edge. The bench also checks that it is zero one cycle before and one cycle after. Every sample is taken on a falling edge, half a period away from any register update. The sweeps cover every line under four base values and every ordered pair of simultaneous lines.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_EOI  = 2'd2,
    SEL_NOP  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
// Synchronizes each request line and emits a one-cycle pulse on a rising edge.
module irq_edge_sync #(
  parameter int N_LINES = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] rise_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[STAGES-1:0], lines_i[g]};
    end
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/prio_pick.sv
// Picks the lowest set index (highest priority) of a vector.
module prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
    onehot_o = any_o ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/isr_gate.sv
// allow_o[i] is set when no level of equal or higher priority is in service.
module isr_gate #(
  parameter int N = 8
) (
  input  logic [N-1:0] isr_i,
  output logic [N-1:0] allow_o
);
  for (genvar g = 0; g < N; g++) begin : g_allow
    assign allow_o[g] = ~|isr_i[g:0];
  end
endmodule

// File: rtl/ack_seq.sv
// Two-pulse acknowledge: first pulse captures the level, second emits the vector.
module ack_seq #(
  parameter int LVL_W  = 3,
  parameter int BASE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ack_i,
  input  logic                    any_i,
  input  logic [LVL_W-1:0]        lvl_i,
  input  logic [BASE_W-1:0]       base_i,
  output logic                    take_o,
  output logic                    busy_o,
  output logic [BASE_W+LVL_W-1:0] vec_o
);
  logic                    phase_q;
  logic [LVL_W-1:0]        lvl_q;
  logic [BASE_W+LVL_W-1:0] vec_q;

  assign take_o = ack_i & ~phase_q & any_i;
  assign busy_o = phase_q;
  assign vec_o  = vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      lvl_q   <= '0;
      vec_q   <= '0;
    end else begin
      vec_q <= '0;
      if (ack_i && !phase_q) begin
        phase_q <= 1'b1;
        lvl_q   <= any_i ? lvl_i : '1;
      end else if (ack_i && phase_q) begin
        phase_q <= 1'b0;
        vec_q   <= {base_i, lvl_q};
      end
    end
  end

  AST_VEC_AFTER_SECOND_ACK: assert property (@(posedge clk) disable iff (rst)
    (vec_q != '0) |-> $past(ack_i && phase_q)); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_LEVELS    = 8,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_LEVELS-1:0] irq_in,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [7:0]          wr_data,
  input  logic                ack,
  output logic                intr,
  output logic [VEC_W-1:0]    vec_out
);
  import pic_pkg::*;

  localparam int LVL_W  = $clog2(N_LEVELS);
  localparam int BASE_W = VEC_W - LVL_W;

  logic [N_LEVELS-1:0] req_q, isr_q, mask_q;
  logic [BASE_W-1:0]   base_q;
  logic                intr_q;

  logic [N_LEVELS-1:0] rise, allow, elig, elig_oh, isr_oh;
  logic [LVL_W-1:0]    elig_idx, isr_idx;
  logic                elig_any, isr_any;
  logic                take, busy;
  wr_sel_e             sel;
  logic                base_wr, mask_wr, eoi_wr;

  irq_edge_sync #(.N_LINES(N_LEVELS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .lines_i(irq_in), .rise_o(rise)
  );

  isr_gate #(.N(N_LEVELS)) u_gate (.isr_i(isr_q), .allow_o(allow));

  assign elig = req_q & ~mask_q & allow;

  prio_pick #(.N(N_LEVELS), .IDX_W(LVL_W)) u_pick_req (
    .vec_i(elig), .any_o(elig_any), .idx_o(elig_idx), .onehot_o(elig_oh)
  );

  prio_pick #(.N(N_LEVELS), .IDX_W(LVL_W)) u_pick_isr (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_idx), .onehot_o(isr_oh)
  );

  ack_seq #(.LVL_W(LVL_W), .BASE_W(BASE_W)) u_ack (
    .clk(clk), .rst(rst), .ack_i(ack), .any_i(elig_any), .lvl_i(elig_idx),
    .base_i(base_q), .take_o(take), .busy_o(busy), .vec_o(vec_out)
  );

  always_comb begin
    sel     = wr_sel_e'(wr_sel);
    base_wr = wr_en && (sel == SEL_BASE);
    mask_wr = wr_en && (sel == SEL_MASK);
    eoi_wr  = wr_en && (sel == SEL_EOI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      isr_q  <= '0;
      mask_q <= '1;
      base_q <= '0;
      intr_q <= 1'b0;
    end else begin
      req_q  <= (req_q & ~(take ? elig_oh : '0)) | rise;
      isr_q  <= (isr_q & ~((eoi_wr && isr_any) ? isr_oh : '0))
              | (take ? elig_oh : '0);
      if (mask_wr) mask_q <= wr_data[N_LEVELS-1:0];
      if (base_wr) base_q <= wr_data[7 -: BASE_W];
      intr_q <= elig_any & ~busy & ~ack;
    end
  end

  assign intr = intr_q;

  AST_MASKED_NO_INTR: assert property (@(posedge clk) disable iff (rst)
    intr_q |-> |($past(req_q) & ~$past(mask_q))); // R3
  AST_INTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (intr_q && !ack && !mask_wr && !$past(mask_wr)) |=> intr_q); // R7
  AST_TAKE_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    take |=> ((isr_q & $past(elig_oh)) == $past(elig_oh))); // R5
  AST_EOI_CLEARS_TOP: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && !take) |=> ((isr_q & $past(isr_oh)) == '0)); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && !intr_q && isr_q == '0)); // R12
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       intr;
  logic [7:0] vec_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack(ack), .intr(intr), .vec_out(vec_out)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic eoi();
    wr(2'd2, 8'hA5);
  endtask

  task automatic ack_pair(output logic [7:0] v);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R6 vec zero between pulses", int'(vec_out), 0);
    chk("R5 intr low after first ack", int'(intr), 0);
    @(negedge clk);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    v = vec_out;
    @(negedge clk);
    chk("R6 vec zero after", int'(vec_out), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] bases [4] = '{8'h48, 8'h0D, 8'h75, 8'hFF};
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R12 intr after reset", int'(intr), 0);
    chk("R12 vec after reset", int'(vec_out), 0);

    // R12: all lines masked after reset
    irq = 8'hFF; tick(8);
    chk("R12 mask set at reset", int'(intr), 0);
    wr(2'd0, 8'hA3);
    wr(2'd1, 8'h00); tick(1);
    chk("R3 unmask raises intr", int'(intr), 1);
    // R1: drain in priority order
    for (int k = 0; k < 8; k++) begin
      ack_pair(v);
      chk("R1 priority order", int'(v), 8'hA0 | k);
      eoi(); tick(2);
    end
    chk("R10 held lines no re-request", int'(intr), 0);
    irq = '0; tick(4);

    // R2/R10/R5 sweep over bases and lines
    foreach (bases[b]) begin
      wr(2'd0, bases[b]);
      for (int i = 0; i < 8; i++) begin
        irq[i] = 1'b1; tick(3);
        chk("R10 intr low after 3 edges", int'(intr), 0);
        tick(1);
        chk("R10 intr high at 4th edge", int'(intr), 1);
        ack_pair(v);
        chk("R2 vector", int'(v), int'((bases[b] & 8'hF8) | 8'(i)));
        chk("R5 request cleared", int'(intr), 0);
        eoi(); tick(4);
        chk("R10 held line stays quiet", int'(intr), 0);
        irq[i] = 1'b0; tick(4);
      end
    end

    // R1: every ordered pair raised together
    wr(2'd0, 8'h48);
    for (int a = 0; a < 8; a++) begin
      for (int b = a + 1; b < 8; b++) begin
        irq = 8'(1 << a) | 8'(1 << b); tick(6);
        ack_pair(v);
        chk("R1 pair first", int'(v), 8'h48 | a);
        eoi(); tick(2);
        chk("R8 eoi lets second through", int'(intr), 1);
        ack_pair(v);
        chk("R1 pair second", int'(v), 8'h48 | b);
        eoi(); irq = '0; tick(4);
      end
    end

    // R3 / R7: masked request waits latched
    wr(2'd1, 8'h04);
    irq[2] = 1'b1; tick(20);
    chk("R3 masked no intr", int'(intr), 0);
    wr(2'd1, 8'h00); tick(1);
    chk("R3 latched request raises intr", int'(intr), 1);
    tick(20);
    chk("R7 intr held while unacknowledged", int'(intr), 1);
    ack_pair(v);
    chk("R3 vector after unmask", int'(v), 8'h4A);
    eoi(); irq = '0; tick(4);

    // R4 / R9 / R8: nesting
    irq[3] = 1'b1; tick(6);
    ack_pair(v);
    chk("R9 first level", int'(v), 8'h4B);
    irq[3] = 1'b0; tick(4);
    irq[3] = 1'b1; tick(6);
    chk("R4 equal priority waits", int'(intr), 0);
    irq[6] = 1'b1; tick(6);
    chk("R4 lower priority waits", int'(intr), 0);
    irq[0] = 1'b1; tick(6);
    chk("R9 higher priority nests", int'(intr), 1);
    ack_pair(v);
    chk("R9 nested vector", int'(v), 8'h48);
    chk("R9 both in service blocks rest", int'(intr), 0);
    eoi(); tick(2);
    chk("R8 only top level cleared", int'(intr), 0);
    eoi(); tick(2);
    chk("R8 second eoi releases", int'(intr), 1);
    ack_pair(v);
    chk("R4 waiting equal request", int'(v), 8'h4B);
    eoi(); tick(2);
    ack_pair(v);
    chk("R4 waiting lower request", int'(v), 8'h4E);
    eoi(); irq = '0; tick(4);

    // R11: acknowledge with nothing eligible
    ack_pair(v);
    chk("R11 empty ack idle", int'(v), 8'h4F);
    chk("R11 no intr after empty ack", int'(intr), 0);
    irq[2] = 1'b1; tick(6);
    ack_pair(v);
    chk("R11 setup level 2", int'(v), 8'h4A);
    irq[4] = 1'b1; tick(6);
    chk("R4 level 4 blocked", int'(intr), 0);
    ack_pair(v);
    chk("R11 empty ack blocked", int'(v), 8'h4F);
    eoi(); tick(2);
    chk("R11 pending kept", int'(intr), 1);
    ack_pair(v);
    chk("R11 pending vector", int'(v), 8'h4C);
    eoi(); tick(2);
    eoi(); tick(2);
    chk("R11 no level 7 in service", int'(intr), 0);
    irq = '0; tick(4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule